// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a 32-bit core's register/address datapath and a big-endian, byte-addressed data memory. The core presents one access: an opcode, an already computed effective address, a 16-bit immediate, the destination register's current value and the store data. The unit checks the address against the access size. It then either raises a one-cycle exception pulse, or issues a single memory request with a word-aligned address, byte enables and lane-placed write data. For loads it formats the returned word into the register result.

Formatting covers sign or zero extension of bytes and halfwords, whole words, an upper-immediate load that never touches memory, and two half-merge loads. One merge load replaces the upper half of the old register value and the other replaces the lower half. The memory side uses a single-outstanding handshake: the request is held until a response-valid is seen. The unit is busy from accept until completion and ignores new requests during that time.

Top module: `lsu_align`

## Requirements
- R1: After reset, `busy`, `mem_req`, `wb_we`, `addr_exc` and `ill_op` are all low.
- R2: Byte loads select the byte at address offset k from lane `mem_rdata[31-8k -: 8]`. Opcode 0x20 sign-extends the byte to 32 bits and opcode 0x24 zero-extends it.
- R3: Halfword loads take lanes [31:16] at offset 0 and lanes [15:0] at offset 2. Opcode 0x21 sign-extends and opcode 0x25 zero-extends. Address bit 0 set raises an address exception.
- R4: Word load 0x23 returns `mem_rdata` unchanged. It raises an address exception unless address bits [1:0] are 00.
- R5: Opcode 0x0F produces `{imm, 16'h0000}` with `wb_we` high in the cycle after accept. It makes no memory request.
- R6: Opcode 0x22 needs address bits [1:0] = 00. It produces `{mem_rdata[31:16], old[15:0]}`.
- R7: Opcode 0x26 needs address bits [1:0] = 11 and reads the word at address minus 3. It produces `{old[31:16], mem_rdata[15:0]}`.
- R8: Stores follow these rules, where enable bit 3 is lane [31:24] and bit 0 is lane [7:0]:
  - 0x28 writes enable bit (3-k) only, with data `{4{d[7:0]}}`.
  - 0x29 writes enables 1100 at offset 0 or 0011 at offset 2, with data `{2{d[15:0]}}`. Address bit 0 set raises an address exception.
  - 0x2B writes enables 1111 with data `d`. It requires bits [1:0] = 00.
- R9: `mem_req` rises in the cycle after accept. While it is high, address, enables, data and `mem_we` stay stable until `mem_rvalid` is sampled. `mem_addr` is the address with bits [1:0] cleared. Loads use the same enable pattern as a store of their size, with 1111 for 0x22 and 0x26.
- R10: A load's `wb_we` is a one-cycle pulse in the cycle after the clock edge at which `mem_rvalid` is seen, with `wb_data` valid during it. A store finishes with `busy` low in that cycle and no `wb_we`.
- R11: A misaligned access pulses `addr_exc` for one cycle, in the cycle after accept, with no memory request, no `wb_we` and `busy` low.
- R12: Any opcode other than the eleven above pulses `ill_op` in the same way as R11, with no memory request and no `wb_we`.
- R13: `req_valid` while `busy` is high is ignored, and `mem_rvalid` with no request outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access presented (taken when not busy) |
| req_op | input | 6 | Access opcode |
| req_addr | input | ADDR_W | Effective byte address |
| req_imm | input | 16 | Immediate for upper-immediate load |
| req_old | input | 32 | Current destination register value |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | Access in progress |
| mem_req | output | 1 | Memory request held until response |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit 3 = lane [31:24] |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory read word |
| wb_we | output | 1 | Register write strobe |
| wb_data | output | 32 | Formatted register result |
| addr_exc | output | 1 | Address exception pulse |
| ill_op | output | 1 | Invalid opcode pulse |

## Verification
The hardest states to reach from the ports are a new access arriving while a load is still waiting for memory, and a response-valid arriving when nothing is outstanding. Both are reached by holding the response off for several cycles, pulsing `req_valid` with a conflicting store during that wait, and then pulsing `mem_rvalid` once the unit is idle. The half-merge loads are driven with an old register value whose halves differ from the memory word, so that a swapped merge shows in the result.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OP_W   = 6;

  localparam logic [OP_W-1:0] OP_LUI = 6'h0F;
  localparam logic [OP_W-1:0] OP_LB  = 6'h20;
  localparam logic [OP_W-1:0] OP_LH  = 6'h21;
  localparam logic [OP_W-1:0] OP_LWH = 6'h22;
  localparam logic [OP_W-1:0] OP_LW  = 6'h23;
  localparam logic [OP_W-1:0] OP_LBU = 6'h24;
  localparam logic [OP_W-1:0] OP_LHU = 6'h25;
  localparam logic [OP_W-1:0] OP_LWL = 6'h26;
  localparam logic [OP_W-1:0] OP_SB  = 6'h28;
  localparam logic [OP_W-1:0] OP_SH  = 6'h29;
  localparam logic [OP_W-1:0] OP_SW  = 6'h2B;

  typedef enum logic [1:0] {K_BAD, K_LUI, K_LOAD, K_STORE} kind_e;
  typedef enum logic [2:0] {F_LB, F_LBU, F_LH, F_LHU, F_LW, F_MHI, F_MLO, F_LUI} fmt_e;
  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_FIN} state_e;

  typedef struct packed {
    kind_e kind;
    fmt_e  fmt;
    size_e size;
    logic  misalign;
  } dec_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_align_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [1:0]      off,
  output dec_t            dec
);
  always_comb begin
    dec.kind     = K_BAD;
    dec.fmt      = F_LW;
    dec.size     = SZ_WORD;
    dec.misalign = 1'b0;
    case (op)
      OP_LUI: begin dec.kind = K_LUI;  dec.fmt = F_LUI; end
      OP_LB:  begin dec.kind = K_LOAD; dec.fmt = F_LB;  dec.size = SZ_BYTE; end
      OP_LBU: begin dec.kind = K_LOAD; dec.fmt = F_LBU; dec.size = SZ_BYTE; end
      OP_LH:  begin dec.kind = K_LOAD; dec.fmt = F_LH;  dec.size = SZ_HALF; dec.misalign = off[0]; end
      OP_LHU: begin dec.kind = K_LOAD; dec.fmt = F_LHU; dec.size = SZ_HALF; dec.misalign = off[0]; end
      OP_LW:  begin dec.kind = K_LOAD; dec.fmt = F_LW;  dec.misalign = (off != 2'b00); end
      OP_LWH: begin dec.kind = K_LOAD; dec.fmt = F_MHI; dec.misalign = (off != 2'b00); end
      OP_LWL: begin dec.kind = K_LOAD; dec.fmt = F_MLO; dec.misalign = (off != 2'b11); end
      OP_SB:  begin dec.kind = K_STORE; dec.size = SZ_BYTE; end
      OP_SH:  begin dec.kind = K_STORE; dec.size = SZ_HALF; dec.misalign = off[0]; end
      OP_SW:  begin dec.kind = K_STORE; dec.misalign = (off != 2'b00); end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_align_pkg::*;
(
  input  size_e             size,
  input  logic [1:0]        off,
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [1:0] BYTE_OFF = 2'(LANES - 1 - i);
    always_comb begin
      case (size)
        SZ_BYTE: begin
          be[i]           = (off == BYTE_OFF);
          wdata[8*i +: 8] = data[7:0];
        end
        SZ_HALF: begin
          be[i]           = (off[1] == BYTE_OFF[1]);
          wdata[8*i +: 8] = (i % 2 == 1) ? data[15:8] : data[7:0];
        end
        default: begin
          be[i]           = 1'b1;
          wdata[8*i +: 8] = data[8*i +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_align_pkg::*;
(
  input  fmt_e              fmt,
  input  logic [1:0]        off,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] old,
  input  logic [15:0]       imm,
  output logic [DATA_W-1:0] result
);
  logic [7:0]  sel_byte;
  logic [15:0] sel_half;

  always_comb begin
    case (off)
      2'd0:    sel_byte = rdata[31:24];
      2'd1:    sel_byte = rdata[23:16];
      2'd2:    sel_byte = rdata[15:8];
      default: sel_byte = rdata[7:0];
    endcase
    sel_half = off[1] ? rdata[15:0] : rdata[31:16];
  end

  always_comb begin
    case (fmt)
      F_LB:    result = {{24{sel_byte[7]}}, sel_byte};
      F_LBU:   result = {24'h0, sel_byte};
      F_LH:    result = {{16{sel_half[15]}}, sel_half};
      F_LHU:   result = {16'h0, sel_half};
      F_MHI:   result = {rdata[31:16], old[15:0]};
      F_MLO:   result = {old[31:16], rdata[15:0]};
      F_LUI:   result = {imm, 16'h0};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_imm,
  input  logic [DATA_W-1:0] req_old,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wb_we,
  output logic [DATA_W-1:0] wb_data,
  output logic              addr_exc,
  output logic              ill_op
);
  state_e            state_q, state_d;
  dec_t              dec;
  logic              accept, is_mem, cap_en;
  logic              exc_d, ill_d;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] wd_c;

  fmt_e              fmt_q;
  logic [1:0]        off_q;
  logic [DATA_W-1:0] old_q, rdata_q, wdata_q;
  logic [15:0]       imm_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic              we_q, exc_q, ill_q;

  lsu_decode u_dec (
    .op  (req_op),
    .off (req_addr[1:0]),
    .dec (dec)
  );

  lsu_store_lane u_lane (
    .size  (dec.size),
    .off   (req_addr[1:0]),
    .data  (req_wdata),
    .be    (be_c),
    .wdata (wd_c)
  );

  assign accept = req_valid && (state_q == ST_IDLE);
  assign is_mem = (dec.kind == K_LOAD) || (dec.kind == K_STORE);
  assign cap_en = (state_q == ST_MEM) && mem_rvalid;

  always_comb begin
    state_d = state_q;
    exc_d   = accept && is_mem && dec.misalign;
    ill_d   = accept && (dec.kind == K_BAD);
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (dec.kind == K_LUI)              state_d = ST_FIN;
          else if (is_mem && !dec.misalign)   state_d = ST_MEM;
        end
      end
      ST_MEM:  if (mem_rvalid) state_d = we_q ? ST_IDLE : ST_FIN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      exc_q   <= 1'b0;
      ill_q   <= 1'b0;
      fmt_q   <= F_LW;
      off_q   <= 2'b00;
      old_q   <= '0;
      imm_q   <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      exc_q   <= exc_d;
      ill_q   <= ill_d;
      if (accept) begin
        fmt_q   <= dec.fmt;
        off_q   <= req_addr[1:0];
        old_q   <= req_old;
        imm_q   <= req_imm;
        addr_q  <= {req_addr[ADDR_W-1:2], 2'b00};
        be_q    <= be_c;
        wdata_q <= (dec.kind == K_STORE) ? wd_c : '0;
        we_q    <= (dec.kind == K_STORE);
      end
      if (cap_en) rdata_q <= mem_rdata;
    end
  end

  lsu_load_fmt u_fmt (
    .fmt    (fmt_q),
    .off    (off_q),
    .rdata  (rdata_q),
    .old    (old_q),
    .imm    (imm_q),
    .result (wb_data)
  );

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_MEM);
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_be    = be_q;
  assign mem_wdata = wdata_q;
  assign wb_we     = (state_q == ST_FIN);
  assign addr_exc  = exc_q;
  assign ill_op    = ill_q;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              mem_rvalid,
  input logic              wb_we,
  input logic              addr_exc,
  input logic              ill_op
);
  a_r9_hold_until_resp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                               && $stable(mem_wdata) && $stable(mem_we));

  a_r9_aligned_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00) &&
                ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  a_r9_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid |=> !mem_req);

  a_r10_load_writes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid && !mem_we |=> wb_we);

  a_r10_store_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid && mem_we |=> !wb_we && !busy);

  a_r10_wb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |=> !wb_we);

  a_r11_exc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    addr_exc |-> !mem_req && !wb_we && !busy && !ill_op);

  a_r12_ill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ill_op |-> !mem_req && !wb_we && !busy);

  a_r13_busy_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !addr_exc && !ill_op);
endmodule

bind lsu_align lsu_align_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .mem_rvalid (mem_rvalid),
  .wb_we      (wb_we),
  .addr_exc   (addr_exc),
  .ill_op     (ill_op)
);

// File: tb/tb_lsu_align.sv
`timescale 1ns/1ps
module tb_lsu_align;
  logic        clk, rst_n;
  logic        req_valid;
  logic [5:0]  req_op;
  logic [31:0] req_addr;
  logic [15:0] req_imm;
  logic [31:0] req_old, req_wdata;
  logic        busy, mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        wb_we;
  logic [31:0] wb_data;
  logic        addr_exc, ill_op;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  lsu_align dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_imm(req_imm), .req_old(req_old),
    .req_wdata(req_wdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .wb_we(wb_we),
    .wb_data(wb_data), .addr_exc(addr_exc), .ill_op(ill_op)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic [31:0] addr,
                       input logic [15:0] imm, input logic [31:0] old,
                       input logic [31:0] sd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr;
    req_imm = imm; req_old = old; req_wdata = sd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic respond(input logic [31:0] rdata);
    mem_rvalid = 1'b1; mem_rdata = rdata;
    @(negedge clk);
    mem_rvalid = 1'b0;
  endtask

  task automatic do_load(input string tag, input logic [5:0] op, input logic [31:0] addr,
                         input logic [31:0] old, input logic [31:0] rdata,
                         input logic [3:0] exp_be, input logic [31:0] exp_addr,
                         input logic [31:0] exp_res, input int wait_n);
    issue(op, addr, 16'h0, old, 32'h0);
    chk({tag, " R9 req"}, mem_req, 1);
    chk({tag, " R9 we"}, mem_we, 0);
    chk({tag, " R9 addr"}, mem_addr, exp_addr);
    chk({tag, " R9 be"}, mem_be, exp_be);
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      chk({tag, " R9 held"}, {mem_req, wb_we, mem_addr[29:0]}, {1'b1, 1'b0, exp_addr[29:0]});
    end
    respond(rdata);
    chk({tag, " R10 req drop"}, mem_req, 0);
    chk({tag, " R10 wb_we"}, wb_we, 1);
    chk({tag, " result"}, wb_data, exp_res);
    @(negedge clk);
    chk({tag, " R10 pulse end"}, {wb_we, busy}, 0);
  endtask

  task automatic do_store(input string tag, input logic [5:0] op, input logic [31:0] addr,
                          input logic [31:0] sd, input logic [3:0] exp_be,
                          input logic [31:0] exp_wd);
    issue(op, addr, 16'h0, 32'h0, sd);
    chk({tag, " R8 req/we"}, {mem_req, mem_we}, 2'b11);
    chk({tag, " R8 addr"}, mem_addr, {addr[31:2], 2'b00});
    chk({tag, " R8 be"}, mem_be, exp_be);
    chk({tag, " R8 wdata"}, mem_wdata, exp_wd);
    respond(32'h0);
    chk({tag, " R10 store done"}, {mem_req, busy, wb_we}, 0);
  endtask

  task automatic do_exc(input string tag, input logic [5:0] op, input logic [31:0] addr,
                        input logic exp_a, input logic exp_i);
    issue(op, addr, 16'h0, 32'h0, 32'hFFFF_FFFF);
    chk({tag, " flags"}, {addr_exc, ill_op}, {exp_a, exp_i});
    chk({tag, " no access"}, {mem_req, busy, wb_we}, 0);
    @(negedge clk);
    chk({tag, " pulse end"}, {addr_exc, ill_op, mem_req, wb_we}, 0);
  endtask

  task automatic do_lui(input logic [15:0] imm, input logic [31:0] exp);
    issue(6'h0F, 32'h0000_2002, imm, 32'hCAFE_F00D, 32'h0);
    chk("R5 lui wb_we", wb_we, 1);
    chk("R5 lui result", wb_data, exp);
    chk("R5 lui no req", mem_req, 0);
    @(negedge clk);
    chk("R5 lui end", {wb_we, busy, mem_req}, 0);
  endtask

  task automatic do_busy_ignore();
    issue(6'h23, 32'h0000_0100, 16'h0, 32'h0, 32'h0);
    req_valid = 1'b1; req_op = 6'h2B; req_addr = 32'h0000_0204; req_wdata = 32'h5555_AAAA;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 busy ignore we", mem_we, 0);
    chk("R13 busy ignore addr", mem_addr, 32'h0000_0100);
    respond(32'h0BAD_F00D);
    chk("R13 first result", wb_data, 32'h0BAD_F00D);
    @(negedge clk);
    chk("R13 no second req", {mem_req, busy}, 0);
    respond(32'h1234_5678);
    chk("R13 stray rvalid", {wb_we, mem_req, busy}, 0);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 6'h0; req_addr = 32'h0;
    req_imm = 16'h0; req_old = 32'h0; req_wdata = 32'h0;
    mem_rvalid = 1'b0; mem_rdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {busy, mem_req, wb_we, addr_exc, ill_op}, 0);

    do_load("R2 lb off0",  6'h20, 32'h0000_1000, 32'h0, 32'h8A5C_F137, 4'b1000, 32'h0000_1000, 32'hFFFF_FF8A, 0);
    do_load("R2 lbu off1", 6'h24, 32'h0000_1001, 32'h0, 32'h8A5C_F137, 4'b0100, 32'h0000_1000, 32'h0000_005C, 2);
    do_load("R2 lb off2",  6'h20, 32'h0000_1002, 32'h0, 32'h8A5C_F137, 4'b0010, 32'h0000_1000, 32'hFFFF_FFF1, 0);
    do_load("R2 lbu off2", 6'h24, 32'h0000_1002, 32'h0, 32'h8A5C_F137, 4'b0010, 32'h0000_1000, 32'h0000_00F1, 0);
    do_load("R2 lb off3",  6'h20, 32'h0000_1003, 32'h0, 32'h8A5C_F137, 4'b0001, 32'h0000_1000, 32'h0000_0037, 1);
    do_load("R3 lh off0",  6'h21, 32'h0000_1000, 32'h0, 32'h8A5C_F137, 4'b1100, 32'h0000_1000, 32'hFFFF_8A5C, 0);
    do_load("R3 lh off2",  6'h21, 32'h0000_1002, 32'h0, 32'h8A5C_F137, 4'b0011, 32'h0000_1000, 32'hFFFF_F137, 0);
    do_load("R3 lhu off2", 6'h25, 32'h0000_1002, 32'h0, 32'h8A5C_F137, 4'b0011, 32'h0000_1000, 32'h0000_F137, 0);
    do_load("R3 lhu off0", 6'h25, 32'h0000_1000, 32'h0, 32'h7A5C_F137, 4'b1100, 32'h0000_1000, 32'h0000_7A5C, 0);
    do_load("R4 lw",       6'h23, 32'h0000_2004, 32'h0, 32'h8A5C_F137, 4'b1111, 32'h0000_2004, 32'h8A5C_F137, 3);
    do_load("R6 merge hi", 6'h22, 32'h0000_3008, 32'hDEAD_BEEF, 32'h8A5C_F137, 4'b1111, 32'h0000_3008, 32'h8A5C_BEEF, 0);
    do_load("R7 merge lo", 6'h26, 32'h0000_300B, 32'hDEAD_BEEF, 32'h8A5C_F137, 4'b1111, 32'h0000_3008, 32'hDEAD_F137, 1);

    do_lui(16'h1234, 32'h1234_0000);
    do_lui(16'hFFFF, 32'hFFFF_0000);

    do_store("R8 sb off1", 6'h28, 32'h0000_4001, 32'h1122_3344, 4'b0100, 32'h4444_4444);
    do_store("R8 sb off3", 6'h28, 32'h0000_4003, 32'h1122_3344, 4'b0001, 32'h4444_4444);
    do_store("R8 sh off0", 6'h29, 32'h0000_4000, 32'h1122_3344, 4'b1100, 32'h3344_3344);
    do_store("R8 sh off2", 6'h29, 32'h0000_4002, 32'h1122_3344, 4'b0011, 32'h3344_3344);
    do_store("R8 sw",      6'h2B, 32'h0000_4004, 32'h1122_3344, 4'b1111, 32'h1122_3344);

    do_exc("R3 lh odd",    6'h21, 32'h0000_5001, 1, 0);
    do_exc("R3 lhu odd",   6'h25, 32'h0000_5003, 1, 0);
    do_exc("R4 lw off2",   6'h23, 32'h0000_5002, 1, 0);
    do_exc("R6 merge hi off1", 6'h22, 32'h0000_5001, 1, 0);
    do_exc("R7 merge lo off1", 6'h26, 32'h0000_5001, 1, 0);
    do_exc("R7 merge lo off0", 6'h26, 32'h0000_5000, 1, 0);
    do_exc("R8 sh odd",    6'h29, 32'h0000_5003, 1, 0);
    do_exc("R8 sw off1",   6'h2B, 32'h0000_5001, 1, 0);
    do_exc("R11 exc check", 6'h2B, 32'h0000_5003, 1, 0);
    do_exc("R12 op 3F",    6'h3F, 32'h0000_5000, 0, 1);
    do_exc("R12 op 27",    6'h27, 32'h0000_5000, 0, 1);
    do_exc("R12 op 00",    6'h00, 32'h0000_5000, 0, 1);

    do_busy_ignore();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule